// File: doc/BRIEF.md
# Byte-Lane Pseudo-SRAM Cycle Controller

This block sits between a synchronous host and an asynchronous pseudo-SRAM with a 16-bit data path and a 20-bit word address. The host presents one request at a time: an address, a direction flag, write data and an active-high enable per byte lane. The controller turns each request into a single timed read or write cycle on the memory pins, then returns a one-cycle acknowledge. Read data comes back with that acknowledge. A request with no lane enabled is acknowledged in the next cycle and leaves the pins idle.

All memory-side timing is counted in clock cycles. The cycle counts come from nanosecond figures for the 60 ns and 70 ns speed grades and are rounded up to whole clock periods. The write strobe must cover the longest of these: the minimum pulse width, chip-select-to-end-of-write, address-to-end-of-write and data setup. That makes the strobe 55 ns on the fast grade and 60 ns on the slow one. The full write cycle is then padded with a recovery phase up to the grade's cycle time. On reads, output enable goes low only after the controller has kept its data drivers off for one full cycle.

The host holds `req` and its fields stable until it sees `ack`. In the cycle where `ack` is high, the host may already present the next request.

Top module: `psram_ctrl`

## Requirements
- R1: A write holds `mem_ce_n` and `mem_we_n` low together for WP cycles, with at least one lane enable low. With the defaults (SPEED_GRADE 70, CLK_NS 10), WP is 6. WP is ceil(max(50, 55 or 60, 25 or 30) / CLK_NS).
- R2: Host enable bit 0 selects the lower lane (`mem_be_n[0]`, data bits 7:0). Bit 1 selects the upper lane (`mem_be_n[1]`, bits 15:8). A lane whose host enable is 0 keeps its `mem_be_n` bit high and its `mem_dq_oe` bit low for the whole cycle. An enabled lane drives the request's byte while `mem_we_n` is low.
- R3: A write is acknowledged WC cycles after it is accepted. WC is ceil(60 or 70 / CLK_NS), and is 7 with the defaults. Any cycles between the end of the strobe and the acknowledge keep every strobe high. In the cycle where `ack` is high, all strobes are high.
- R4: A read keeps `mem_ce_n` low, `mem_we_n` high and the enabled lanes' `mem_be_n` low for RD cycles. `mem_oe_n` is high in the first of these cycles and low in the rest. RD is max(ceil(60 or 70 / CLK_NS), ceil(20 / CLK_NS) + 1), and is 7 with the defaults.
- R5: Read data is sampled at the end of the last read cycle and appears on `rdata` together with `ack`. A disabled lane's byte reads as zero.
- R6: `mem_oe_n` is never low while any `mem_dq_oe` bit is high. `mem_oe_n` only falls after a cycle in which no lane was driven.
- R7: A request with both host enables 0 is acknowledged in the cycle after acceptance. It leaves every memory strobe high, and the stored data is unchanged.
- R8: `mem_addr` equals the request address and stays stable while `mem_ce_n` is low.
- R9: During and right after a synchronous reset, all strobes and lane enables are high, no lane is driven, and `ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request present; held until `ack` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Active-high lane enables, bit 0 = lower byte |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with `ack` |
| mem_addr | output | 20 | Memory address bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 0 = lower byte |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 2 | Per-lane driver enable for `mem_dq_o` |
| mem_dq_i | input | 16 | Data returned by the memory |

## Verification
A phase counter that is off by one shows within a single transaction. Either the strobe ends a cycle early or late against the cycle-accurate model, or `ack` moves, and both are checked on every clock. A wrong lane register shows up as a byte driven on the wrong half of the bus or a byte with the wrong value. It is caught in the same cycle on the driver enables, or at the next read-back of that address through `rdata`. A turnaround fault, where output enable drops while a lane is still driven, is flagged on the very edge where it happens.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_STRB,
        ST_WR_REC,
        ST_RD_TURN,
        ST_RD_WAIT
    } state_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    // full cycle time for reads and writes
    function automatic int cycle_ns(input int grade);
        return (grade == 60) ? 60 : 70;
    endfunction

    // strobe must cover pulse width, select/address to end of write, data setup
    function automatic int strobe_ns(input int grade);
        int sel_ns;
        int dsu_ns;
        sel_ns = (grade == 60) ? 55 : 60;
        dsu_ns = (grade == 60) ? 25 : 30;
        return imax(imax(50, sel_ns), dsu_ns);
    endfunction

    function automatic int oe_access_ns();
        return 20;
    endfunction

endpackage

// File: rtl/psram_phase_timer.sv
module psram_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/psram_lane.sv
module psram_lane #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              en,
    input  logic              is_wr,
    input  logic [LANE_W-1:0] wbyte,
    input  logic              drop,
    input  logic              capture,
    input  logic [LANE_W-1:0] din,
    output logic              lane_n,
    output logic [LANE_W-1:0] dq_o,
    output logic              dq_oe,
    output logic [LANE_W-1:0] rbyte
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lane_n <= 1'b1;
            dq_o   <= '0;
            dq_oe  <= 1'b0;
            rbyte  <= '0;
        end else begin
            if (start && en) begin
                lane_n <= 1'b0;
                if (is_wr) begin
                    dq_o  <= wbyte;
                    dq_oe <= 1'b1;
                end
            end
            if (drop) begin
                lane_n <= 1'b1;
                dq_oe  <= 1'b0;
            end
            if (capture)
                rbyte <= lane_n ? '0 : din;
        end
    end
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_ctrl_pkg::*;
#(
    parameter int SPEED_GRADE = 70,
    parameter int CLK_NS      = 10,
    parameter int ADDR_W      = 20,
    parameter int LANE_W      = 8,
    parameter int LANES       = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req,
    input  logic                    req_we,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LANE_W*LANES-1:0] req_wdata,
    input  logic [LANES-1:0]        req_be,
    output logic                    ack,
    output logic [LANE_W*LANES-1:0] rdata,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_ce_n,
    output logic                    mem_we_n,
    output logic                    mem_oe_n,
    output logic [LANES-1:0]        mem_be_n,
    output logic [LANE_W*LANES-1:0] mem_dq_o,
    output logic [LANES-1:0]        mem_dq_oe,
    input  logic [LANE_W*LANES-1:0] mem_dq_i
);
    localparam int WP_CYC   = ns_to_cyc(strobe_ns(SPEED_GRADE), CLK_NS);
    localparam int WC_CYC   = imax(ns_to_cyc(cycle_ns(SPEED_GRADE), CLK_NS), WP_CYC);
    localparam int REC_CYC  = WC_CYC - WP_CYC;
    localparam int RD_CYC   = imax(ns_to_cyc(cycle_ns(SPEED_GRADE), CLK_NS),
                                   ns_to_cyc(oe_access_ns(), CLK_NS) + 1);
    localparam int CNT_W    = $clog2(imax(WC_CYC, RD_CYC) + 1);
    localparam int REC_LOAD = (REC_CYC > 0) ? REC_CYC - 1 : 0;

    state_t            state, state_d;
    strobe_t           strb, strb_d;
    logic              ack_d;
    logic              t_load, t_zero;
    logic [CNT_W-1:0]  t_val;
    logic              ln_start, ln_drop, ln_capture;
    logic [ADDR_W-1:0] addr_q;

    psram_phase_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    always_comb begin
        state_d    = state;
        strb_d     = strb;
        ack_d      = 1'b0;
        t_load     = 1'b0;
        t_val      = '0;
        ln_start   = 1'b0;
        ln_drop    = 1'b0;
        ln_capture = 1'b0;
        case (state)
            ST_IDLE: begin
                if (req && (req_be != '0)) begin
                    ln_start    = 1'b1;
                    strb_d.ce_n = 1'b0;
                    strb_d.we_n = ~req_we;
                    t_load      = 1'b1;
                    t_val       = req_we ? CNT_W'(WP_CYC - 1) : '0;
                    state_d     = req_we ? ST_WR_STRB : ST_RD_TURN;
                end else if (req) begin
                    ack_d = 1'b1;
                end
            end
            ST_WR_STRB: begin
                if (t_zero) begin
                    ln_drop = 1'b1;
                    strb_d  = STROBE_IDLE;
                    if (REC_CYC == 0) begin
                        ack_d   = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        t_load  = 1'b1;
                        t_val   = CNT_W'(REC_LOAD);
                        state_d = ST_WR_REC;
                    end
                end
            end
            ST_WR_REC: begin
                if (t_zero) begin
                    ack_d   = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_RD_TURN: begin
                strb_d.oe_n = 1'b0;
                t_load      = 1'b1;
                t_val       = CNT_W'(RD_CYC - 2);
                state_d     = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (t_zero) begin
                    ln_capture = 1'b1;
                    ln_drop    = 1'b1;
                    strb_d     = STROBE_IDLE;
                    ack_d      = 1'b1;
                    state_d    = ST_IDLE;
                end
            end
            default: begin
                strb_d  = STROBE_IDLE;
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            strb   <= STROBE_IDLE;
            ack    <= 1'b0;
            addr_q <= '0;
        end else begin
            state <= state_d;
            strb  <= strb_d;
            ack   <= ack_d;
            if (ln_start)
                addr_q <= req_addr;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        psram_lane #(.LANE_W(LANE_W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .start   (ln_start),
            .en      (req_be[g]),
            .is_wr   (req_we),
            .wbyte   (req_wdata[g*LANE_W +: LANE_W]),
            .drop    (ln_drop),
            .capture (ln_capture),
            .din     (mem_dq_i[g*LANE_W +: LANE_W]),
            .lane_n  (mem_be_n[g]),
            .dq_o    (mem_dq_o[g*LANE_W +: LANE_W]),
            .dq_oe   (mem_dq_oe[g]),
            .rbyte   (rdata[g*LANE_W +: LANE_W])
        );
    end

    assign mem_addr = addr_q;
    assign mem_ce_n = strb.ce_n;
    assign mem_we_n = strb.we_n;
    assign mem_oe_n = strb.oe_n;
endmodule

// File: rtl/psram_ctrl_checker.sv
module psram_ctrl_checker #(
    parameter int ADDR_W = 20,
    parameter int LANES  = 2,
    parameter int MIN_WP = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [LANES-1:0]  mem_be_n,
    input logic [LANES-1:0]  mem_dq_oe
);
    logic [7:0] we_low_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            we_low_cnt <= '0;
        else if (!mem_we_n) begin
            if (we_low_cnt != 8'hFF)
                we_low_cnt <= we_low_cnt + 1'b1;
        end else
            we_low_cnt <= '0;
    end

    a_r1_write_overlap: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && !(&mem_be_n)));

    a_r1_pulse_width: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_low_cnt >= 8'(MIN_WP)));

    a_r2_lane_drive: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe != '0) |-> (((mem_dq_oe & mem_be_n) == '0) && !mem_we_n));

    a_r3_ack_idle: assert property (@(posedge clk) disable iff (rst)
        ack |-> (mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n)));

    a_r4_read_qual: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n && !(&mem_be_n)));

    a_r6_no_clash: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_dq_oe == '0));

    a_r6_turnaround: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> ($past(mem_dq_oe) == '0 && !$past(mem_ce_n)));

    a_r8_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    a_r9_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_ce_n && mem_we_n && mem_oe_n && !ack && (mem_dq_oe == '0)));
endmodule

bind psram_ctrl psram_ctrl_checker #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .MIN_WP (WP_CYC)
) u_chk (.*);

// File: tb/psram_ctrl_bench.sv
module psram_ctrl_bench;
    localparam int CLK = 10;
    // expected phase counts for the 70 ns grade at 10 ns clock
    localparam int WP = (60 + CLK - 1) / CLK;
    localparam int WC = (70 + CLK - 1) / CLK;
    localparam int RD = (70 + CLK - 1) / CLK;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        ack;
    logic [15:0] rdata;
    logic [19:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n;
    logic [1:0]  mem_be_n, mem_dq_oe;
    logic [15:0] mem_dq_o;
    logic [15:0] mem_dq_i = 16'hFFFF;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] dev_mem [int];
    logic [15:0] ref_mem [int];

    always #5 clk = ~clk;

    psram_ctrl u_psram_ctrl (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .ack(ack), .rdata(rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // behavioural memory device on the pins
    always @(negedge clk) begin
        logic [15:0] w;
        int a;
        a = int'(mem_addr);
        w = dev_mem.exists(a) ? dev_mem[a] : 16'h0000;
        if (!mem_ce_n && !mem_we_n) begin
            for (int i = 0; i < 2; i++)
                if (mem_dq_oe[i] && !mem_be_n[i]) w[i*8 +: 8] = mem_dq_o[i*8 +: 8];
            dev_mem[a] = w;
        end
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            for (int i = 0; i < 2; i++)
                mem_dq_i[i*8 +: 8] = mem_be_n[i] ? 8'h5A : w[i*8 +: 8];
        end else
            mem_dq_i = 16'hFFFF;
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic bus(input string tag, input bit ce, input bit we, input bit oe,
                       input logic [1:0] be_n, input logic [1:0] oe_lanes, input bit a);
        chk(tag, "ce_n", 32'(mem_ce_n), 32'(ce));
        chk(tag, "we_n", 32'(mem_we_n), 32'(we));
        chk(tag, "oe_n", 32'(mem_oe_n), 32'(oe));
        chk(tag, "be_n", 32'(mem_be_n), 32'(be_n));
        chk(tag, "dq_oe", 32'(mem_dq_oe), 32'(oe_lanes));
        chk(tag, "ack", 32'(ack), 32'(a));
    endtask

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    // called at a negedge; returns at the negedge of the ack cycle
    task automatic do_op(input bit we, input logic [19:0] a, input logic [15:0] d,
                         input logic [1:0] be, input string tag);
        logic [15:0] m;
        logic [15:0] r;
        m = lane_mask(be);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        if (be == 2'b00) begin
            // R7: acknowledged at once, no strobe
            bus(tag, 1, 1, 1, 2'b11, 2'b00, 1);
        end else if (we) begin
            for (int k = 0; k <= WC; k++) begin
                if (k > 0) @(negedge clk);
                if (k < WP) begin
                    bus(tag, 0, 0, 1, ~be, be, 0);
                    chk(tag, "addr", 32'(mem_addr), 32'(a));
                    chk(tag, "wdata", 32'(mem_dq_o & m), 32'(d & m));
                end else
                    bus(tag, 1, 1, 1, 2'b11, 2'b00, (k == WC));
            end
            r = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
            ref_mem[int'(a)] = (r & ~m) | (d & m);
        end else begin
            for (int k = 0; k <= RD; k++) begin
                if (k > 0) @(negedge clk);
                if (k < RD) begin
                    bus(tag, 0, 1, (k == 0), ~be, 2'b00, 0);
                    chk(tag, "addr", 32'(mem_addr), 32'(a));
                end else begin
                    bus(tag, 1, 1, 1, 2'b11, 2'b00, 1);
                    r = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
                    chk(tag, "rdata", 32'(rdata), 32'(r & m));
                end
            end
        end
        req = 1'b0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus(tag, 1, 1, 1, 2'b11, 2'b00, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        bus("R9", 1, 1, 1, 2'b11, 2'b00, 0);   // R9 during reset
        rst = 1'b0;
        idle(2, "R9");                          // R9 after reset
        do_op(1, 20'h00005, 16'hA1B2, 2'b11, "R1");
        idle(1, "R3");
        do_op(1, 20'h00009, 16'h1234, 2'b01, "R2");  // R2 lower lane only
        do_op(1, 20'h00009, 16'hCDEF, 2'b10, "R2");  // R2 upper lane, back to back
        do_op(0, 20'h00009, 16'h0000, 2'b11, "R5");  // R5 merged word 0xCD34
        do_op(0, 20'h00005, 16'h0000, 2'b01, "R5");  // R5 upper reads zero
        do_op(0, 20'h00005, 16'h0000, 2'b10, "R4");  // R4 upper-only read
        do_op(1, 20'h00005, 16'hFFFF, 2'b00, "R7");  // R7 masked write
        idle(2, "R7");
        do_op(0, 20'h00005, 16'h0000, 2'b11, "R7");  // R7 data unchanged
        do_op(0, 20'h00005, 16'h0000, 2'b00, "R7");
        do_op(1, 20'hFFFFF, 16'h5AA5, 2'b11, "R8");  // R8 top address
        do_op(0, 20'hFFFFF, 16'h0000, 2'b11, "R6");  // R6 write then read turnaround
        do_op(1, 20'h00000, 16'h0F0F, 2'b11, "R1");
        do_op(0, 20'h00000, 16'h0000, 2'b11, "R5");
        idle(3, "R3");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule